// File: doc/BRIEF.md
# Registered I/O Cell

This block models one programmable I/O cell of a configurable logic fabric. It sits between an external pad, represented by separate input, output and output-enable signals, and the internal logic array. Every path is `W` bits wide, one bit per pad.

The pad output comes either from an output register or straight from array data, as a configuration bit selects. Pad input is always captured in an input register. Both registers share one clock. They also share one asynchronous global control that clears or presets them, and a configuration bit chooses which of the two it does. The array-side read port returns either the registered pad input or the current output-register value. The second choice lets a state machine keep its state in the pad register.

Top module: `rio_cell`

## Requirements
- R1: While `rst_ni` is low, both registers hold 0. `pad_o` therefore reads 0 when `cfg_oreg_i`=1, and `arr_q_o` reads 0 for either setting of `cfg_fb_sel_i`.
- R2: With `cfg_oreg_i`=1, `pad_o` equals the `arr_d_i` value sampled at the most recent rising clock edge.
- R3: With `cfg_oreg_i`=0, `pad_o` follows `arr_d_i` in the same cycle, with no clock edge needed.
- R4: With `cfg_fb_sel_i`=0, `arr_q_o` equals the `pad_i` value sampled at the most recent rising clock edge.
- R5: With `cfg_fb_sel_i`=1, `arr_q_o` equals the output register value. That register loads `arr_d_i` on every edge, whether or not it is bypassed.
- R6: While `gctl_i`=1 and `cfg_preset_i`=0, both registers are forced to all zeros and ignore clock edges.
- R7: While `gctl_i`=1 and `cfg_preset_i`=1, both registers are forced to all ones and ignore clock edges.
- R8: The force from `gctl_i` acts asynchronously. `arr_q_o` shows the forced value before the next clock edge.
- R9: `pad_oe_o` equals `arr_oe_i` combinationally in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock for both registers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gctl_i | input | 1 | Global asynchronous clear/preset, active high |
| cfg_preset_i | input | 1 | 0: the global control clears; 1: it presets |
| cfg_oreg_i | input | 1 | 1: register the output path; 0: bypass the register |
| cfg_fb_sel_i | input | 1 | 0: return registered pad input; 1: return output register |
| arr_d_i | input | W | Data from the array toward the pad |
| arr_oe_i | input | W | Output enable from the array |
| pad_i | input | W | Value seen at the pad |
| pad_o | output | W | Value driven to the pad |
| pad_oe_o | output | W | Output enable to the pad |
| arr_q_o | output | W | Read data returned to the array |

## Verification
The bench builds the cell at its default width of 8. At that width random data gives mixed bit patterns, so a bit swap or a stuck bit shows up. All four combinations of bypass and feedback select are run, each over many cycles. The global control is raised in the middle of a cycle, in both clear and preset mode, with feedback selected. This shows whether the force acts before the next clock edge and whether it holds across an edge.

// File: rtl/rio_pkg.sv
package rio_pkg;
  typedef enum logic {GCTL_CLEAR = 1'b0, GCTL_PRESET = 1'b1} gctl_mode_e;
endpackage

// File: rtl/rio_flop.sv
module rio_flop #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gctl_i,
  input  logic         preset_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  import rio_pkg::*;

  logic [W-1:0] force_val;
  assign force_val = (gctl_mode_e'(preset_i) == GCTL_PRESET) ? '1 : '0;

  always_ff @(posedge clk_i or negedge rst_ni or posedge gctl_i) begin
    if (!rst_ni)     q_o <= '0;
    else if (gctl_i) q_o <= force_val;
    else             q_o <= d_i;
  end

  assert_gctl_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gctl_i && $past(gctl_i) && !preset_i && !$past(preset_i)) |-> (q_o == '0));

  assert_gctl_preset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gctl_i && $past(gctl_i) && preset_i && $past(preset_i)) |-> (q_o == '1));
endmodule

// File: rtl/rio_out_path.sv
module rio_out_path #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gctl_i,
  input  logic         preset_i,
  input  logic         oreg_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] oe_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] q_o
);
  logic [W-1:0] oreg_q;

  rio_flop #(.W(W)) u_oreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .gctl_i(gctl_i), .preset_i(preset_i),
    .d_i(d_i), .q_o(oreg_q)
  );

  assign pad_o    = oreg_i ? oreg_q : d_i;
  assign pad_oe_o = oe_i;
  assign q_o      = oreg_q;
endmodule

// File: rtl/rio_in_path.sv
module rio_in_path #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gctl_i,
  input  logic         preset_i,
  input  logic         fb_sel_i,
  input  logic [W-1:0] pad_i,
  input  logic [W-1:0] fb_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ireg_q;

  rio_flop #(.W(W)) u_ireg (
    .clk_i(clk_i), .rst_ni(rst_ni), .gctl_i(gctl_i), .preset_i(preset_i),
    .d_i(pad_i), .q_o(ireg_q)
  );

  assign q_o = fb_sel_i ? fb_i : ireg_q;
endmodule

// File: rtl/rio_cell.sv
module rio_cell #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gctl_i,
  input  logic         cfg_preset_i,
  input  logic         cfg_oreg_i,
  input  logic         cfg_fb_sel_i,
  input  logic [W-1:0] arr_d_i,
  input  logic [W-1:0] arr_oe_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] arr_q_o
);
  logic [W-1:0] fb_q;

  rio_out_path #(.W(W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .gctl_i(gctl_i), .preset_i(cfg_preset_i),
    .oreg_i(cfg_oreg_i), .d_i(arr_d_i), .oe_i(arr_oe_i),
    .pad_o(pad_o), .pad_oe_o(pad_oe_o), .q_o(fb_q)
  );

  rio_in_path #(.W(W)) u_in (
    .clk_i(clk_i), .rst_ni(rst_ni), .gctl_i(gctl_i), .preset_i(cfg_preset_i),
    .fb_sel_i(cfg_fb_sel_i), .pad_i(pad_i), .fb_i(fb_q), .q_o(arr_q_o)
  );

  // edge-to-edge relations, skipped around reset release and the global control
  assert_oreg_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && cfg_oreg_i && !gctl_i && !$past(gctl_i))
      |-> (pad_o == $past(arr_d_i)));

  assert_ireg_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !cfg_fb_sel_i && !gctl_i && !$past(gctl_i))
      |-> (arr_q_o == $past(pad_i)));

  assert_feedback_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_fb_sel_i && cfg_oreg_i) |-> (arr_q_o == pad_o));
endmodule

// File: tb/tb_rio_cell.sv
module tb_rio_cell;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         gctl = 1'b0, preset = 1'b0, oreg = 1'b1, fb = 1'b0;
  logic [W-1:0] arr_d = '0, arr_oe = '0, pad_in = '0;
  logic [W-1:0] pad_out, pad_oe, arr_q;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] m_out = '0, m_in = '0;

  always #5 clk = ~clk;

  rio_cell #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .gctl_i(gctl), .cfg_preset_i(preset),
    .cfg_oreg_i(oreg), .cfg_fb_sel_i(fb), .arr_d_i(arr_d), .arr_oe_i(arr_oe),
    .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe), .arr_q_o(arr_q)
  );

  // behavioural reference: two storage words
  always @(posedge clk or negedge rst_n or posedge gctl) begin
    if (!rst_n) begin
      m_out <= '0; m_in <= '0;
    end else if (gctl) begin
      m_out <= {W{preset}}; m_in <= {W{preset}};
    end else begin
      m_out <= arr_d; m_in <= pad_in;
    end
  end

  task automatic cmp(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic check_all(string gtag);
    logic [W-1:0] e_pad, e_q;
    e_pad = oreg ? m_out : arr_d;
    e_q   = fb ? m_out : m_in;
    cmp(gtag != "" ? gtag : (oreg ? "R2 pad_o" : "R3 pad_o"), pad_out, e_pad);
    cmp(gtag != "" ? gtag : (fb ? "R5 arr_q_o" : "R4 arr_q_o"), arr_q, e_q);
    cmp("R9 pad_oe_o", pad_oe, arr_oe);
  endtask

  task automatic drive_rand();
    arr_d  = W'($urandom);
    arr_oe = W'($urandom);
    pad_in = W'($urandom);
  endtask

  task automatic gctl_test(logic p, string tag);
    @(negedge clk);
    check_all("");
    fb = 1'b1; oreg = 1'b1; preset = p;
    drive_rand();
    #2 gctl = 1'b1;
    #1 cmp({tag, " R8 async arr_q_o"}, arr_q, {W{p}});
    cmp({tag, " R8 async pad_o"}, pad_out, {W{p}});
    @(negedge clk);
    cmp({tag, " held across edge"}, arr_q, {W{p}});
    fb = 1'b0;
    #1 cmp({tag, " input reg forced"}, arr_q, {W{p}});
    gctl = 1'b0;
    fb = 1'b1;
    drive_rand();
    @(negedge clk);
    check_all("");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    drive_rand();
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1 pad_o in reset", pad_out, '0);
    fb = 1'b0; #1 cmp("R1 arr_q_o in reset (input reg)", arr_q, '0);
    fb = 1'b1; #1 cmp("R1 arr_q_o in reset (feedback)", arr_q, '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int mode = 0; mode < 4; mode++) begin
      oreg = mode[0];
      fb   = mode[1];
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        check_all("");
        drive_rand();
        #1 check_all("");
      end
    end
    gctl_test(1'b0, "R6 clear");
    gctl_test(1'b1, "R7 preset");
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      check_all("");
      oreg = c[0];
      fb   = c[1];
      drive_rand();
    end
    @(negedge clk);
    check_all("");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule